// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block joins two 8-bit buses, called A and B, through a non-inverting link that can work in either direction. Each direction has a storage register with its own clock. The register for the A-to-B direction samples bus A, and the register for the B-to-A direction samples bus B. For each direction, a select input chooses what goes to the far bus: the live data from the source bus, or the stored register value. A per-direction enable decides whether the far bus is driven at all. The A-to-B enable is active high and the B-to-A enable is active low.

Each bus is split into three vectors: an input, an output and a per-bit output enable. The bus value the block sees is its own output on any bit it drives, and the external input on any bit it does not drive. A register always loads this resolved value, so stored data can be fed back through a bus or copied into both registers. The live path to a far bus always takes the external input of the source bus. As a result, a loop cannot form when both buses are driven with live data.

Top module: `dual_reg_xcvr`

## Requirements
- R1: When the A bus is not driven by the block, a rising edge of `a2b_clk` loads `a_in` into the A-to-B register.
- R2: When the B bus is not driven by the block, a rising edge of `b2a_clk` loads `b_in` into the B-to-A register.
- R3: `b_out` equals `a_in` when `a2b_use_reg` is 0 and equals the A-to-B register when it is 1. The value is non-inverted and valid whatever the enable state.
- R4: `a_out` equals `b_in` when `b2a_use_reg` is 0 and equals the B-to-A register when it is 1. The value is non-inverted and valid whatever the enable state.
- R5: Outside reset, every bit of `b_oe` equals `a2b_en` (1 drives) and every bit of `a_oe` equals the inverse of `b2a_en_n` (0 drives). Both follow their pins with no clock.
- R6: While `rst_n` is 0, both registers read as zero and `a_oe` and `b_oe` are all zero. Both registers read zero after release until their next load.
- R7: Loading is never gated. When the block drives A (`b2a_en_n` = 0), an `a2b_clk` edge loads `a_out` rather than `a_in`.
- R8: With `a2b_en` = 1, `a2b_use_reg` = 0 and `b2a_en_n` = 1, a `b2a_clk` edge loads the live A data into the B-to-A register. After that edge both registers can hold A data.
- R9: With `a2b_en` = 0 and `b2a_en_n` = 1, neither bus is driven. Either register still loads from its bus external input.
- R10: When both buses are driven and both selects are 0, `b_out` equals `a_in` and `a_out` equals `b_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| a2b_clk | input | 1 | Load clock of the A-to-B register |
| b2a_clk | input | 1 | Load clock of the B-to-A register |
| a2b_en | input | 1 | Drive B, active high |
| b2a_en_n | input | 1 | Drive A, active low |
| a2b_use_reg | input | 1 | 1: stored data to B, 0: live A data |
| b2a_use_reg | input | 1 | 1: stored data to A, 0: live B data |
| a_in | input | W | External value on bus A |
| a_out | output | W | Value offered to bus A |
| a_oe | output | W | Per-bit drive enable of bus A |
| b_in | input | W | External value on bus B |
| b_out | output | W | Value offered to bus B |
| b_oe | output | W | Per-bit drive enable of bus B |

## Verification
A register holding the wrong value stays hidden while its select is 0. It shows at the far bus output as soon as that select is set to 1, with no clock needed. The bench therefore reads both registers back through the stored path after every step. A fault in the bus resolution, such as loading `a_in` where the block drives A, shows only after the next load edge. It surfaces on the following readback, one edge after the fault. Enable faults show at once on the `_oe` vectors, for every combination of enables.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Source chosen for the far bus of one direction
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  // R1 R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(d)));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         en,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out,
  output logic [W-1:0] oe
);
  function automatic logic pick(input src_e s, input logic st, input logic lv);
    return (s == SRC_STORED) ? st : lv;
  endfunction

  src_e src;
  assign src = src_e'(sel);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out[i] = pick(src, stored[i], live[i]);
    assign oe[i]  = en;
  end

  // R3 R4
  stored_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel |-> (out == stored));
  // R3 R4
  live_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (out == live));
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_n,
  input  logic         a2b_clk,
  input  logic         b2a_clk,
  input  logic         a2b_en,
  input  logic         b2a_en_n,
  input  logic         a2b_use_reg,
  input  logic         b2a_use_reg,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  function automatic logic resolve(input logic drv, input logic own, input logic ext);
    return drv ? own : ext;
  endfunction

  // Named internal events for the checks
  logic         drive_a, drive_b;
  logic [W-1:0] a_seen, b_seen;
  logic [W-1:0] a2b_q, b2a_q;

  assign drive_b = a2b_en & rst_n;
  assign drive_a = ~b2a_en_n & rst_n;

  for (genvar i = 0; i < W; i++) begin : g_res
    assign a_seen[i] = resolve(a_oe[i], a_out[i], a_in[i]);
    assign b_seen[i] = resolve(b_oe[i], b_out[i], b_in[i]);
  end

  xcvr_store #(.W(W)) u_a2b_reg (
    .clk(a2b_clk), .rst_n(rst_n), .d(a_seen), .q(a2b_q)
  );
  xcvr_store #(.W(W)) u_b2a_reg (
    .clk(b2a_clk), .rst_n(rst_n), .d(b_seen), .q(b2a_q)
  );

  xcvr_drive #(.W(W)) u_to_b (
    .clk(a2b_clk), .rst_n(rst_n), .sel(a2b_use_reg), .en(drive_b),
    .live(a_in), .stored(a2b_q), .out(b_out), .oe(b_oe)
  );
  xcvr_drive #(.W(W)) u_to_a (
    .clk(b2a_clk), .rst_n(rst_n), .sel(b2a_use_reg), .en(drive_a),
    .live(b_in), .stored(b2a_q), .out(a_out), .oe(a_oe)
  );

  // R5
  b_oe_uniform_chk: assert property (@(posedge a2b_clk) disable iff (!rst_n)
    ($countones(b_oe) == 0) || ($countones(b_oe) == W));
  // R5
  a_oe_uniform_chk: assert property (@(posedge b2a_clk) disable iff (!rst_n)
    ($countones(a_oe) == 0) || ($countones(a_oe) == W));
  // R7
  feedback_load_chk: assert property (@(posedge a2b_clk) disable iff (!rst_n)
    (a_oe != '0) |=> (a2b_q == $past(a_out)));
endmodule

// File: tb/sim_dual_reg_xcvr.sv
module sim_dual_reg_xcvr;
  localparam int W = 8;
  localparam int PER = 10;

  logic rst_n = 1'b0, a2b_clk = 1'b0, b2a_clk = 1'b0;
  logic a2b_en = 1'b0, b2a_en_n = 1'b1, a2b_use_reg = 1'b0, b2a_use_reg = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_ab, m_ba;
  logic done = 1'b0;

  dual_reg_xcvr #(.W(W)) u0 (
    .rst_n(rst_n), .a2b_clk(a2b_clk), .b2a_clk(b2a_clk),
    .a2b_en(a2b_en), .b2a_en_n(b2a_en_n),
    .a2b_use_reg(a2b_use_reg), .b2a_use_reg(b2a_use_reg),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_b_out();
    return a2b_use_reg ? m_ab : a_in;
  endfunction
  function automatic logic [W-1:0] exp_a_out();
    return b2a_use_reg ? m_ba : b_in;
  endfunction
  function automatic logic [W-1:0] exp_a_seen();
    return (!b2a_en_n) ? exp_a_out() : a_in;
  endfunction
  function automatic logic [W-1:0] exp_b_seen();
    return a2b_en ? exp_b_out() : b_in;
  endfunction

  task automatic tick_ab();
    a2b_clk = 1'b1; #(PER/2); a2b_clk = 1'b0; #(PER/2);
  endtask
  task automatic tick_ba();
    b2a_clk = 1'b1; #(PER/2); b2a_clk = 1'b0; #(PER/2);
  endtask
  task automatic tick_both();
    a2b_clk = 1'b1; b2a_clk = 1'b1; #(PER/2);
    a2b_clk = 1'b0; b2a_clk = 1'b0; #(PER/2);
  endtask

  task automatic check_outs();
    chk("R3", b_out, exp_b_out());
    chk("R4", a_out, exp_a_out());
    chk("R5", b_oe, {W{a2b_en}});
    chk("R5", a_oe, {W{~b2a_en_n}});
    if (a2b_en && !b2a_en_n && !a2b_use_reg && !b2a_use_reg) begin
      chk("R10", b_out, a_in);
      chk("R10", a_out, b_in);
    end
  endtask

  // Reads both registers through the stored path; restores selects after
  task automatic readback(input string tag_ab, input string tag_ba);
    logic s1, s2;
    s1 = a2b_use_reg; s2 = b2a_use_reg;
    a2b_use_reg = 1'b1; b2a_use_reg = 1'b1; #1;
    chk(tag_ab, b_out, m_ab);
    chk(tag_ba, a_out, m_ba);
    a2b_use_reg = s1; b2a_use_reg = s2; #1;
  endtask

  initial begin
    #(PER * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    string t_ab, t_ba;
    // R6: reset state
    a2b_en = 1'b1; b2a_en_n = 1'b0; a_in = 8'hA5; b_in = 8'h3C;
    #2;
    chk("R6", a_oe, '0);
    chk("R6", b_oe, '0);
    tick_both();
    #2; rst_n = 1'b1; a2b_en = 1'b0; b2a_en_n = 1'b1; #2;
    m_ab = '0; m_ba = '0;
    readback("R6", "R6");

    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 8; p++) begin
        a2b_en = c[0]; b2a_en_n = c[1]; a2b_use_reg = c[2]; b2a_use_reg = c[3];
        a_in = W'(c * 29 + p * 53 + 7);
        b_in = W'((c * 71) ^ (p * 19) ^ 8'hC3);
        #1; check_outs();
        t_ab = (!b2a_en_n) ? "R7" : "R1";
        if (a2b_en && !a2b_use_reg && b2a_en_n) t_ba = "R8";
        else if (a2b_en) t_ba = "R2";
        else if (b2a_en_n) t_ba = "R9";
        else t_ba = "R2";
        if (!a2b_en && b2a_en_n) t_ab = "R9";
        if (!a2b_use_reg && !b2a_use_reg && p[0]) begin
          logic [W-1:0] na, nb;
          na = exp_a_seen(); nb = exp_b_seen();
          tick_both();
          m_ab = na; m_ba = nb;
          readback(t_ab, t_ba);
        end else begin
          m_ab = exp_a_seen();
          tick_ab();
          check_outs();
          readback(t_ab, "R2");
          m_ba = exp_b_seen();
          tick_ba();
          check_outs();
          readback(t_ab, t_ba);
        end
        if (t_ba == "R8") chk("R8", m_ba, a_in);
      end
    end

    // R6: mid-run reset clears registers and releases buses
    a2b_en = 1'b1; b2a_en_n = 1'b0; #1;
    rst_n = 1'b0; #1;
    chk("R6", a_oe, '0);
    chk("R6", b_oe, '0);
    tick_both();
    rst_n = 1'b1; a2b_en = 1'b0; b2a_en_n = 1'b1; #2;
    m_ab = '0; m_ba = '0;
    readback("R6", "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule